// File: doc/BRIEF.md
# Multi-Ring Sampled Bit Combiner

This block turns a set of free-running ring oscillator signals into a stream of random bits and keeps that stream in on-chip storage so it can be read out later for offline statistical testing. Every ring has its own sampling flip-flop. All sampling flip-flops are loaded on the same irregular sample strobe, not on a fixed-rate tick. The sampled bits are reduced by a full XOR into one raw bit per strobe.

A post-processing stage XORs each pair of consecutive raw bits into one output bit, so the output rate is half the strobe rate. The output bits are packed into 32-bit words, least significant bit first, and written into a buffer memory at ascending addresses. Once the buffer is full it accepts no more writes until a clear pulse restarts capture at address zero. Each ring input is asynchronous, so it is brought into the system clock domain by a two-flop synchronizer before the sampler loads it. The ring count is a parameter, and builds with 5, 10 and 25 rings are intended.

Top module: `ring_bit_harvester`

## Requirements
- R1: While `sample_stb` is low, changes on `ring_in` do not produce an output bit. `bit_valid` stays 0.
- R2: A ring value is sampled only if it was present on `ring_in` at least two rising clock edges before the strobe edge. A value that changes in the half cycle just before the strobe edge gives the previous value.
- R3: The raw bit of a strobe is the XOR of all `NUM_RINGS` sampled ring bits, so every ring flips it. This holds for any ring count, including 5, 10 and 25.
- R4: Counting strobes from reset, the raw bits of strobes 2k-1 and 2k are XORed into one output bit on `bit_out`. `bit_valid` pulses for one cycle, two rising edges after the edge of strobe 2k. No pulse follows an odd-numbered strobe.
- R5: Output bits are packed into 32-bit words with the first bit at bit 0. The n-th completed word is written to address n-1.
- R6: `mem_full` rises on the edge that writes word `MEM_WORDS`-1. After that, further output bits are dropped and the stored words do not change.
- R7: A one-cycle `clear` pulse lowers `mem_full` on the next edge and discards any partly packed word. Capture then restarts at address 0, bit 0. The pairing order of R4 is not affected.
- R8: `rd_data` holds the word stored at `rd_addr` one rising edge after `rd_addr` is applied.
- R9: After reset, `bit_valid` and `mem_full` are 0 and the pairing starts with the first strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ring_in | input | NUM_RINGS | Free-running oscillator signals, one per ring |
| sample_stb | input | 1 | One-cycle non-periodic sample strobe |
| clear | input | 1 | Restart capture and lower the full flag |
| rd_addr | input | $clog2(MEM_WORDS) | Buffer read address |
| rd_data | output | 32 | Stored word, one edge after the address |
| bit_out | output | 1 | Post-processed random bit |
| bit_valid | output | 1 | One-cycle pulse qualifying `bit_out` |
| mem_full | output | 1 | Buffer full, writes stopped |

## Verification
A wrong pairing phase shows up at once at the ports: `bit_valid` pulses after the wrong strobe, on the very first strobe after reset or after the first strobe that follows the error. A wrong bit position or a wrong write pointer in the packer stays hidden until a word is read back, which can be up to 64 strobes later. A wrong full flag shows up on the strobe that completes the last word, either as an early or late `mem_full` or as changed contents after further strobes. A missing synchronizer stage is caught only by a ring value that changes just before a strobe, so the bench drives that case on purpose.

// File: rtl/rbh_pkg.sv
package rbh_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned BIT_IDX_W = $clog2(WORD_W);
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/rbh_sampler.sv
// One synchronizer and one strobe-loaded sampler per ring, then a full XOR.
module rbh_sampler #(
  parameter int unsigned NUM_RINGS   = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_RINGS-1:0] ring_in,
  input  logic                 stb,
  output logic                 raw_bit,
  output logic                 raw_vld
);
  logic [NUM_RINGS-1:0] samp_vec;
  logic                 raw_vld_q;

  for (genvar g = 0; g < NUM_RINGS; g++) begin : g_ring
    logic [SYNC_STAGES-1:0] sync_q, sync_d;
    logic                   samp_q, samp_d;

    always_comb begin
      sync_d = {sync_q[SYNC_STAGES-2:0], ring_in[g]};
      samp_d = stb ? sync_q[SYNC_STAGES-1] : samp_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_q <= '0;
        samp_q <= 1'b0;
      end else begin
        sync_q <= sync_d;
        samp_q <= samp_d;
      end
    end

    assign samp_vec[g] = samp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_vld_q <= 1'b0;
    else        raw_vld_q <= stb;
  end

  assign raw_bit = ^samp_vec;
  assign raw_vld = raw_vld_q;
endmodule

// File: rtl/rbh_pair_xor.sv
// Folds each pair of consecutive raw bits into one output bit.
module rbh_pair_xor (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_bit,
  input  logic raw_vld,
  output logic bit_out,
  output logic bit_vld
);
  logic half_q, half_d;
  logic first_q, first_d;
  logic out_q, out_d;
  logic vld_q, vld_d;

  always_comb begin
    half_d  = half_q;
    first_d = first_q;
    out_d   = out_q;
    vld_d   = 1'b0;
    if (raw_vld) begin
      if (!half_q) begin
        first_d = raw_bit;
        half_d  = 1'b1;
      end else begin
        out_d  = first_q ^ raw_bit;
        vld_d  = 1'b1;
        half_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q  <= 1'b0;
      first_q <= 1'b0;
      out_q   <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      half_q  <= half_d;
      first_q <= first_d;
      out_q   <= out_d;
      vld_q   <= vld_d;
    end
  end

  assign bit_out = out_q;
  assign bit_vld = vld_q;
endmodule

// File: rtl/rbh_capture.sv
// Packs bits LSB first into words and stores them until the buffer is full.
module rbh_capture
  import rbh_pkg::*;
#(
  parameter int unsigned MEM_WORDS = 8,
  localparam int unsigned ADDR_W   = $clog2(MEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_in,
  input  logic              bit_vld,
  input  logic              clear,
  input  logic [ADDR_W-1:0] rd_addr,
  output word_t             rd_data,
  output logic              full
);
  word_t                acc_q, acc_d, acc_next;
  logic [BIT_IDX_W-1:0] pos_q, pos_d;
  logic [ADDR_W-1:0]    wptr_q, wptr_d;
  logic                 full_q, full_d;
  logic                 take, word_done, we;
  word_t                mem_q [MEM_WORDS];
  word_t                rd_q;

  always_comb begin
    take      = bit_vld & ~full_q;
    acc_next  = acc_q | (word_t'(bit_in) << pos_q);
    word_done = take && (pos_q == BIT_IDX_W'(WORD_W - 1));
    we        = word_done & ~clear;
    acc_d     = acc_q;
    pos_d     = pos_q;
    wptr_d    = wptr_q;
    full_d    = full_q;
    if (clear) begin
      acc_d  = '0;
      pos_d  = '0;
      wptr_d = '0;
      full_d = 1'b0;
    end else if (take) begin
      if (word_done) begin
        acc_d  = '0;
        pos_d  = '0;
        wptr_d = wptr_q + 1'b1;
        full_d = (wptr_q == ADDR_W'(MEM_WORDS - 1));
      end else begin
        acc_d = acc_next;
        pos_d = pos_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      pos_q  <= '0;
      wptr_q <= '0;
      full_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      pos_q  <= pos_d;
      wptr_q <= wptr_d;
      full_q <= full_d;
    end
  end

  always_ff @(posedge clk) begin
    if (we) mem_q[wptr_q] <= acc_next;
    rd_q <= mem_q[rd_addr];
  end

  assign rd_data = rd_q;
  assign full    = full_q;
endmodule

// File: rtl/ring_bit_harvester.sv
module ring_bit_harvester
  import rbh_pkg::*;
#(
  parameter int unsigned NUM_RINGS   = 5,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MEM_WORDS   = 8,
  localparam int unsigned ADDR_W     = $clog2(MEM_WORDS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_RINGS-1:0] ring_in,
  input  logic                 sample_stb,
  input  logic                 clear,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [WORD_W-1:0]    rd_data,
  output logic                 bit_out,
  output logic                 bit_valid,
  output logic                 mem_full
);
  logic [1:0] rst_pipe_q;
  logic       core_rst_n;
  logic       raw_bit, raw_vld;
  logic       pp_bit, pp_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign core_rst_n = rst_pipe_q[1];

  rbh_sampler #(.NUM_RINGS(NUM_RINGS), .SYNC_STAGES(SYNC_STAGES)) u_samp (
    .clk(clk), .rst_n(core_rst_n), .ring_in(ring_in), .stb(sample_stb),
    .raw_bit(raw_bit), .raw_vld(raw_vld)
  );

  rbh_pair_xor u_pair (
    .clk(clk), .rst_n(core_rst_n), .raw_bit(raw_bit), .raw_vld(raw_vld),
    .bit_out(pp_bit), .bit_vld(pp_vld)
  );

  rbh_capture #(.MEM_WORDS(MEM_WORDS)) u_cap (
    .clk(clk), .rst_n(core_rst_n), .bit_in(pp_bit), .bit_vld(pp_vld),
    .clear(clear), .rd_addr(rd_addr), .rd_data(rd_data), .full(mem_full)
  );

  assign bit_out   = pp_bit;
  assign bit_valid = pp_vld;
endmodule

// File: rtl/rbh_checker.sv
module rbh_checker (
  input logic clk,
  input logic rst_n,
  input logic sample_stb,
  input logic clear,
  input logic bit_valid,
  input logic mem_full
);
  p_bit_after_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> $past(sample_stb, 2));
  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |=> !bit_valid);
  p_full_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_full && !clear) |=> mem_full);
  p_full_on_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_full) |-> $past(bit_valid));
  p_clear_drops_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !mem_full);
endmodule

bind ring_bit_harvester rbh_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .clear(clear),
  .bit_valid(bit_valid), .mem_full(mem_full)
);

// File: tb/sim_ring_bit_harvester.sv
module sim_ring_bit_harvester;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 5;
  localparam int MW = 8;
  localparam int AW = $clog2(MW);

  logic          clk = 1'b0;
  logic          rst_n, sample_stb, clear;
  logic [NR-1:0] ring_in;
  logic [AW-1:0] rd_addr;
  logic [31:0]   rd_data;
  logic          bit_out, bit_valid, mem_full;

  int n_chk = 0, n_fail = 0;
  logic [NR-1:0] held;
  logic          half, first, last_b, last_v;
  logic [31:0]   m_acc;
  logic [31:0]   m_mem [MW];
  int            m_pos, m_wp;
  logic          m_full;
  logic [15:0]   lfsr;

  always #(CLK_PERIOD/2) clk = ~clk;

  ring_bit_harvester #(.NUM_RINGS(NR), .MEM_WORDS(MW)) u0 (
    .clk(clk), .rst_n(rst_n), .ring_in(ring_in), .sample_stb(sample_stb),
    .clear(clear), .rd_addr(rd_addr), .rd_data(rd_data), .bit_out(bit_out),
    .bit_valid(bit_valid), .mem_full(mem_full)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic model_push(input logic b);
    if (!m_full) begin
      m_acc[m_pos] = b;
      m_pos++;
      if (m_pos == 32) begin
        m_mem[m_wp] = m_acc;
        m_acc = '0; m_pos = 0; m_wp++;
        if (m_wp == MW) m_full = 1'b1;
      end
    end
  endtask

  // one strobe; late=1 changes the ring in the half cycle before the strobe edge
  task automatic strobe(input logic [NR-1:0] pat, input bit late);
    logic [NR-1:0] cap;
    logic raw;
    if (late) cap = held;
    else begin
      ring_in = pat;
      repeat (3) @(negedge clk);
      cap = pat;
    end
    ring_in = pat; held = pat;
    sample_stb = 1'b1;
    @(negedge clk);
    sample_stb = 1'b0;
    @(negedge clk);
    raw = ^cap;
    last_v = bit_valid; last_b = bit_out;
    if (half) begin
      check(bit_valid === 1'b1 && bit_out === (first ^ raw), "R4 pair bit",
            {30'd0, bit_valid, bit_out}, {30'd0, 1'b1, first ^ raw});
      model_push(first ^ raw);
      half = 1'b0;
    end else begin
      check(bit_valid === 1'b0, "R4 no pulse on odd strobe", {31'd0, bit_valid}, 32'd0);
      first = raw; half = 1'b1;
    end
    @(negedge clk);
    check(mem_full === m_full, "R6 full flag", {31'd0, mem_full}, {31'd0, m_full});
  endtask

  task automatic next_pat(output logic [NR-1:0] p);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    p = lfsr[NR-1:0] ^ lfsr[15:11];
  endtask

  task automatic read_word(input int a, input string req);
    rd_addr = AW'(a);
    @(negedge clk);
    check(rd_data === m_mem[a], req, rd_data, m_mem[a]);
  endtask

  task automatic t_reset;
    check(bit_valid === 1'b0, "R9 reset valid", {31'd0, bit_valid}, 32'd0);
    check(mem_full === 1'b0, "R9 reset full", {31'd0, mem_full}, 32'd0);
  endtask

  task automatic t_no_strobe;
    bit seen = 0;
    for (int i = 0; i < 12; i++) begin
      ring_in = NR'(i * 7);
      @(negedge clk);
      if (bit_valid !== 1'b0) seen = 1;
    end
    ring_in = held;
    repeat (3) @(negedge clk);
    check(!seen, "R1 ring toggles without strobe", {31'd0, seen}, 32'd0);
  endtask

  task automatic t_each_ring;
    for (int i = 0; i < NR; i++) begin
      strobe('0, 0);
      strobe(NR'(1) << i, 0);
      check(last_v === 1'b1 && last_b === 1'b1, "R3 single ring flips raw bit",
            {30'd0, last_v, last_b}, 32'd3);
    end
    strobe('1, 0);
    strobe(NR'(3), 0);
    check(last_b === 1'b1, "R3 all rings vs two rings", {31'd0, last_b}, 32'd1);
  endtask

  task automatic t_sync;
    strobe('0, 0);
    strobe(NR'(1), 1);
    check(last_b === 1'b0, "R2 late change not sampled", {31'd0, last_b}, 32'd0);
    strobe(NR'(1), 0);
    strobe('0, 0);
    check(last_b === 1'b1, "R2 held value sampled", {31'd0, last_b}, 32'd1);
  endtask

  task automatic t_fill;
    logic [NR-1:0] p;
    while (!m_full) begin
      next_pat(p);
      strobe(p, 0);
    end
    for (int a = 0; a < MW; a++) read_word(a, "R5 R8 stored word");
    for (int k = 0; k < 40; k++) begin
      next_pat(p);
      strobe(p, 0);
    end
    for (int a = 0; a < MW; a++) read_word(a, "R6 contents frozen when full");
  endtask

  task automatic t_clear;
    logic [NR-1:0] p;
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    m_acc = '0; m_pos = 0; m_wp = 0; m_full = 1'b0;
    check(mem_full === 1'b0, "R7 clear lowers full", {31'd0, mem_full}, 32'd0);
    while (m_wp < 1) begin
      next_pat(p);
      strobe(p, 0);
    end
    read_word(0, "R7 restart at address 0");
    check(mem_full === 1'b0, "R7 not full after one word", {31'd0, mem_full}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sample_stb = 1'b0; clear = 1'b0; ring_in = '0; rd_addr = '0;
    held = '0; half = 1'b0; first = 1'b0; last_b = 1'b0; last_v = 1'b0;
    m_acc = '0; m_pos = 0; m_wp = 0; m_full = 1'b0; lfsr = 16'hACE1;
    for (int a = 0; a < MW; a++) m_mem[a] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_no_strobe();
    t_each_ring();
    t_sync();
    t_fill();
    t_clear();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule